// File: doc/BRIEF.md
# Reset Sequencer with Self-Test Pass

This block steps a chip through three timed reset phases and, at the end of the third phase, can launch a built-in self-test pass through a start/done handshake with an external test engine. When the engine reports completion, the sequencer resets itself and runs the three phases again. A completion bit is kept through that internal reset, so the second pass skips the test and enters run mode. Run mode enables the core clock.

Three kinds of request start the sequence: power-on reset (the synchronous `rst_n`), destructive resets and short functional resets. A short functional reset never launches the test. Software can also switch the test off with a bypass bit. That bit is writable only after a two-word key unlock. A small register bus gives access to the key register, the run register (which holds bypass) and a set of sticky event flags. The flags record which sources and which test completions have occurred.

Top module: `rst_seq_top`

## Requirements
- R1: After any reset request the sequence holds phase 1, then phase 2, then phase 3, each for exactly PHASE_CYC clock cycles. `phase_o` encodes these as 1, 2 and 3. It is 3 while a test is in progress and 0 in run mode.
- R2: When phase 3 ends and the test is not skipped, `st_start` pulses high for one cycle. The sequencer then waits in the test state (phase 3) until `st_done`.
- R3: After `st_done` the sequence is back in phase 1 on the next cycle. The test-complete bit is kept, so the next phase 3 enters run mode (`run_mode`=1) without a second `st_start`.
- R4: A destructive request, or power-on reset, clears the test-complete bit, so the following pass runs the test again. Any request that arrives in the middle of the sequence restarts it at phase 1 on the next cycle.
- R5: A sequence started by a short functional request never asserts `st_start` and ends in run mode.
- R6: The flag register (address 2) has bit0 power-on, bit1 destructive, bit2 short functional and bit3 self-test done. Each bit is set by its event. After a pass that ran the test, bit3 is set together with the bit of the triggering source.
- R7: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. Only power-on reset clears flags otherwise, and power-on reset leaves only bit0 set. The internal self-test reset never clears a flag.
- R8: The key register is at address 0. Writing 32'hA5C30F96 and then 32'h5A3CF069, as consecutive key writes, unlocks the run register. Reading address 0 returns bit0=1 while unlocked. Any key write that breaks the order returns the lock to locked.
- R9: Bit0 of the run register (address 1) is the bypass bit. A write changes it only while unlocked, and it reads back at address 1. Power-on reset clears it.
- R10: While bypass is 1, no sequence asserts `st_start`, and each reset sequence proceeds to run mode.
- R11: `core_clk_en` is low during every reset phase and during the test, and high in run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| req_destr | input | 1 | Destructive reset request, one cycle per request |
| req_short | input | 1 | Short functional reset request, one cycle per request |
| st_done | input | 1 | Self-test engine completion pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| phase_o | output | 2 | Current phase: 1, 2, 3, or 0 in run mode |
| st_start | output | 1 | One-cycle self-test launch pulse |
| run_mode | output | 1 | High in run mode |
| core_clk_en | output | 1 | Core clock enable |

## Verification
The sequence is driven from power-on, from destructive requests, from short requests, and with bypass set. Together these separate the four outcomes: a test followed by re-entry, no test at all, a test that is run again because the sticky bit was cleared, and a test suppressed by software. A request injected during phase 2 shows the mid-sequence restart. Key sequences in the right order, in the wrong order and with a wrong word show whether the unlock is gated correctly. Selective write-1-to-clear patterns on the flags show that each bit is cleared on its own.

// File: rtl/rst_seq_pkg.sv
// Package: shared encodings for the reset sequencer.
// Assumes: register addresses are 2 bits wide.
package rst_seq_pkg;
    typedef enum logic [2:0] {
        S_PH1  = 3'd0,
        S_PH2  = 3'd1,
        S_PH3  = 3'd2,
        S_TEST = 3'd3,
        S_RUN  = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        K_LOCKED = 2'd0,
        K_HALF   = 2'd1,
        K_OPEN   = 2'd2
    } key_state_e;

    localparam logic [1:0] ADDR_KEY  = 2'd0;
    localparam logic [1:0] ADDR_RUN  = 2'd1;
    localparam logic [1:0] ADDR_FLAG = 2'd2;

    localparam int NFLAG    = 4;
    localparam int FL_POR   = 0;
    localparam int FL_DESTR = 1;
    localparam int FL_SHORT = 2;
    localparam int FL_STDN  = 3;
endpackage

// File: rtl/rst_seq_fsm.sv
// Module: phase sequencer. It runs three timed phases, launches the self-test
// at the end of phase 3 unless the test is skipped, and restarts at phase 1
// when the test ends. A sticky done bit then skips the test on the next pass.
// Assumes: requests and st_done are single-cycle pulses synchronous to clk.
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int PHASE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_destr,
    input  logic       req_short,
    input  logic       st_done,
    input  logic       bypass,
    output logic [1:0] phase_o,
    output logic       st_start,
    output logic       run_mode,
    output logic       core_clk_en,
    output logic       pass_evt
);
    localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

    seq_state_e    st;
    logic [CW-1:0] cnt;
    logic          sticky_done;
    logic          short_seq;
    logic          skip;
    logic          phase_end;

    // Decide whether phase 3 skips the test and whether a phase ends now.
    always_comb begin
        skip      = sticky_done | short_seq | bypass;
        phase_end = (cnt == LAST);
        pass_evt  = (st == S_TEST) && st_done && !req_destr && !req_short;
    end

    // Advance the state, the phase counter and the sticky bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= S_PH1;
            cnt         <= '0;
            sticky_done <= 1'b0;
            short_seq   <= 1'b0;
            st_start    <= 1'b0;
        end else if (req_destr) begin
            st          <= S_PH1;
            cnt         <= '0;
            sticky_done <= 1'b0;
            short_seq   <= 1'b0;
            st_start    <= 1'b0;
        end else if (req_short) begin
            st          <= S_PH1;
            cnt         <= '0;
            short_seq   <= 1'b1;
            st_start    <= 1'b0;
        end else begin
            st_start <= 1'b0;
            unique case (st)
                S_PH1, S_PH2: begin
                    if (phase_end) begin
                        st  <= (st == S_PH1) ? S_PH2 : S_PH3;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_PH3: begin
                    if (phase_end) begin
                        cnt <= '0;
                        if (skip) begin
                            st <= S_RUN;
                        end else begin
                            st       <= S_TEST;
                            st_start <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_TEST: begin
                    if (st_done) begin
                        st          <= S_PH1;
                        cnt         <= '0;
                        sticky_done <= 1'b1;
                        short_seq   <= 1'b0;
                    end
                end
                default: st <= S_RUN;
            endcase
        end
    end

    // Decode the state into the phase number, run mode and clock enable.
    always_comb begin
        unique case (st)
            S_PH1:   phase_o = 2'd1;
            S_PH2:   phase_o = 2'd2;
            S_PH3:   phase_o = 2'd3;
            S_TEST:  phase_o = 2'd3;
            default: phase_o = 2'd0;
        endcase
        run_mode    = (st == S_RUN);
        core_clk_en = run_mode;
    end

    // R2: the launch pulse lasts one cycle.
    a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_start |=> !st_start);
    // R2: a launch is always followed by the wait for the test result.
    a_r2_start_wait: assert property (@(posedge clk) disable iff (!rst_n)
        st_start |-> (st == S_TEST));
    // R3: completion sends the sequence back to phase 1.
    a_r3_reentry: assert property (@(posedge clk) disable iff (!rst_n)
        pass_evt |=> (phase_o == 2'd1 && !st_start));
    // R4: a destructive request restarts the sequence at phase 1.
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        req_destr |=> (phase_o == 2'd1));
    // R1: the phase counter stays inside one phase length.
    a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    // R5 and R10: a skipped pass never launches the test.
    a_r10_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PH3 && phase_end && skip && !req_destr && !req_short)
        |=> !st_start);
    // R11: the core clock is off whenever a phase number is shown.
    a_r11_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 2'd0) |-> !core_clk_en);
endmodule

// File: rtl/rst_seq_keylock.sv
// Module: two-key unlock and the protected run register, which holds bypass.
// Assumes: one bus write per cycle; key words are given as parameters.
module rst_seq_keylock
    import rst_seq_pkg::*;
#(
    parameter logic [31:0] KEY1 = 32'hA5C3_0F96,
    parameter logic [31:0] KEY2 = 32'h5A3C_F069
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic        unlocked,
    output logic        bypass
);
    key_state_e lk;
    logic       key_wr;
    logic       run_wr;

    // Decode the bus strobes for the key and run registers.
    always_comb begin
        key_wr   = reg_wr && (reg_addr == ADDR_KEY);
        run_wr   = reg_wr && (reg_addr == ADDR_RUN);
        unlocked = (lk == K_OPEN);
    end

    // Step the unlock machine on key writes; any broken order relocks it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk <= K_LOCKED;
        end else if (key_wr) begin
            if (lk == K_HALF && reg_wdata == KEY2) begin
                lk <= K_OPEN;
            end else if (reg_wdata == KEY1) begin
                lk <= K_HALF;
            end else begin
                lk <= K_LOCKED;
            end
        end
    end

    // Hold the bypass bit; it changes only on a run write while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bypass <= 1'b0;
        end else if (run_wr && unlocked) begin
            bypass <= reg_wdata[0];
        end
    end

    // R9: a run write while locked leaves bypass unchanged.
    a_r9_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (run_wr && !unlocked) |=> $stable(bypass));
    // R8: a key word other than the expected one relocks the machine.
    a_r8_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && reg_wdata != KEY1 && !(lk == K_HALF && reg_wdata == KEY2))
        |=> (lk == K_LOCKED));
    // R8: unlocking always passes through the half-open state.
    a_r8_order: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(unlocked)) |-> ($past(lk) == K_HALF));
endmodule

// File: rtl/rst_seq_flags.sv
// Module: sticky event flags with write-1-to-clear. A set wins over a clear
// in the same cycle. Assumes: event inputs are single-cycle pulses.
module rst_seq_flags
    import rst_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] ev,
    input  logic             clr_wr,
    input  logic [NFLAG-1:0] clr_mask,
    output logic [NFLAG-1:0] flags
);
    logic [NFLAG-1:0] clr;

    // Form the clear mask from a write to the flag register.
    always_comb clr = clr_wr ? clr_mask : '0;

    // Apply the clears, then the sets; power-on leaves only its own bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= NFLAG'(1) << FL_POR;
        end else begin
            flags <= (flags & ~clr) | ev;
        end
    end

    // R7: without a clear write, no flag falls.
    a_r7_no_spont_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((flags & $past(flags)) == $past(flags)));
    // R6: every event leaves its flag set.
    a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((flags & $past(ev)) == $past(ev)));
endmodule

// File: rtl/rst_seq_top.sv
// Module: top of the reset sequencer. It ties the phase sequencer, the key
// lock and the flags to the register bus and decodes register reads.
// Assumes: rst_n is the power-on reset, already synchronous to clk.
module rst_seq_top
    import rst_seq_pkg::*;
#(
    parameter int          PHASE_CYC = 4,
    parameter logic [31:0] KEY1      = 32'hA5C3_0F96,
    parameter logic [31:0] KEY2      = 32'h5A3C_F069
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_destr,
    input  logic        req_short,
    input  logic        st_done,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic [1:0]  phase_o,
    output logic        st_start,
    output logic        run_mode,
    output logic        core_clk_en
);
    logic             bypass;
    logic             unlocked;
    logic             pass_evt;
    logic [NFLAG-1:0] flags;
    logic [NFLAG-1:0] ev;

    rst_seq_fsm #(.PHASE_CYC(PHASE_CYC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_destr   (req_destr),
        .req_short   (req_short),
        .st_done     (st_done),
        .bypass      (bypass),
        .phase_o     (phase_o),
        .st_start    (st_start),
        .run_mode    (run_mode),
        .core_clk_en (core_clk_en),
        .pass_evt    (pass_evt)
    );

    rst_seq_keylock #(.KEY1(KEY1), .KEY2(KEY2)) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .unlocked  (unlocked),
        .bypass    (bypass)
    );

    // Collect the flag events from the requests and the test completion.
    always_comb begin
        ev           = '0;
        ev[FL_DESTR] = req_destr;
        ev[FL_SHORT] = req_short;
        ev[FL_STDN]  = pass_evt;
    end

    rst_seq_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .clr_wr   (reg_wr && reg_addr == ADDR_FLAG),
        .clr_mask (reg_wdata[NFLAG-1:0]),
        .flags    (flags)
    );

    // Return the register addressed by reg_addr.
    always_comb begin
        unique case (reg_addr)
            ADDR_KEY:  reg_rdata = {31'd0, unlocked};
            ADDR_RUN:  reg_rdata = {31'd0, bypass};
            ADDR_FLAG: reg_rdata = {{(32-NFLAG){1'b0}}, flags};
            default:   reg_rdata = '0;
        endcase
    end

    // R11: run mode and the core clock enable agree with the phase output.
    a_r11_run_clock: assert property (@(posedge clk) disable iff (!rst_n)
        run_mode |-> (core_clk_en && phase_o == 2'd0));
endmodule

// File: tb/sim_rst_seq_top.sv
module sim_rst_seq_top;
    localparam int PC = 4;
    localparam logic [31:0] K1 = 32'hA5C3_0F96;
    localparam logic [31:0] K2 = 32'h5A3C_F069;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_destr = 1'b0;
    logic        req_short = 1'b0;
    logic        st_done = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  phase_o;
    logic        st_start;
    logic        run_mode;
    logic        core_clk_en;

    int n_chk = 0;
    int n_fail = 0;
    int n_start = 0;
    int resp_cnt = 0;

    always #4 clk = ~clk;

    rst_seq_top #(.PHASE_CYC(PC), .KEY1(K1), .KEY2(K2)) u0 (
        .clk(clk), .rst_n(rst_n), .req_destr(req_destr), .req_short(req_short),
        .st_done(st_done), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .phase_o(phase_o),
        .st_start(st_start), .run_mode(run_mode), .core_clk_en(core_clk_en)
    );

    // Model of the test engine: answers each launch with done three cycles later.
    always @(negedge clk) begin
        if (st_start) begin
            n_start  = n_start + 1;
            resp_cnt = 3;
            st_done  = 1'b0;
        end else if (resp_cnt > 0) begin
            resp_cnt = resp_cnt - 1;
            st_done  = (resp_cnt == 0);
        end else begin
            st_done = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_run(output int cyc);
        cyc = 0;
        while (!run_mode && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic pulse_destr();
        @(negedge clk);
        n_start = 0;
        req_destr = 1'b1;
        @(negedge clk);
        req_destr = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 phase in reset", 32'(phase_o), 32'd1);
        check("R11 clock gated in reset", 32'(core_clk_en), 32'd0);
        rd(2'd2, d);
        check("R7 flags after power-on", d, 32'h1);
        rd(2'd1, d);
        check("R9 bypass cleared by power-on", d, 32'h0);
    endtask

    task automatic t_por_flow();
        int n2, cyc;
        logic [31:0] d;
        n_start = 0;
        rst_n = 1'b1;
        n2 = 0;
        while (phase_o != 2'd2) @(negedge clk);
        while (phase_o == 2'd2) begin n2++; @(negedge clk); end
        check("R1 phase 2 length", 32'(n2), 32'(PC));
        while (n_start == 0) @(negedge clk);
        check("R2 phase held at 3 during test", 32'(phase_o), 32'd3);
        check("R11 clock gated during test", 32'(core_clk_en), 32'd0);
        while (!st_done) @(negedge clk);
        @(negedge clk);
        check("R3 re-entry at phase 1", 32'(phase_o), 32'd1);
        wait_run(cyc);
        check("R3 run mode after second pass", 32'(run_mode), 32'd1);
        check("R3 single launch", 32'(n_start), 32'd1);
        check("R11 clock on in run", 32'(core_clk_en), 32'd1);
        check("R1 phase 0 in run", 32'(phase_o), 32'd0);
        rd(2'd2, d);
        check("R6 power-on and test flags", d, 32'h9);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(2'd2, 32'h8);
        rd(2'd2, d);
        check("R7 selective clear", d, 32'h1);
        wr(2'd2, 32'h0);
        rd(2'd2, d);
        check("R7 zero write keeps flags", d, 32'h1);
        wr(2'd2, 32'hF);
        rd(2'd2, d);
        check("R7 full clear", d, 32'h0);
    endtask

    task automatic t_destr();
        int cyc;
        logic [31:0] d;
        pulse_destr();
        wait_run(cyc);
        check("R4 destructive reruns test", 32'(n_start), 32'd1);
        rd(2'd2, d);
        check("R6 destructive and test flags", d, 32'hA);
        wr(2'd2, 32'hF);
    endtask

    task automatic t_short();
        int cyc;
        logic [31:0] d;
        @(negedge clk);
        n_start = 0;
        req_short = 1'b1;
        @(negedge clk);
        req_short = 1'b0;
        check("R4 short request restarts at phase 1", 32'(phase_o), 32'd1);
        wait_run(cyc);
        check("R5 short reset reaches run", 32'(run_mode), 32'd1);
        check("R5 short reset no launch", 32'(n_start), 32'd0);
        rd(2'd2, d);
        check("R6 short flag only", d, 32'h4);
        wr(2'd2, 32'hF);
    endtask

    task automatic t_midseq();
        int cyc;
        pulse_destr();
        while (phase_o != 2'd2) @(negedge clk);
        @(negedge clk);
        req_destr = 1'b1;
        @(negedge clk);
        req_destr = 1'b0;
        check("R4 mid-sequence restart", 32'(phase_o), 32'd1);
        wait_run(cyc);
        check("R4 run after restart", 32'(run_mode), 32'd1);
        wr(2'd2, 32'hF);
    endtask

    task automatic t_keylock();
        logic [31:0] d;
        wr(2'd1, 32'h1);
        rd(2'd1, d);
        check("R9 locked write ignored", d, 32'h0);
        wr(2'd0, K2);
        wr(2'd0, K1);
        rd(2'd0, d);
        check("R8 reversed order stays locked", d, 32'h0);
        wr(2'd0, 32'h1234_5678);
        wr(2'd0, K2);
        rd(2'd0, d);
        check("R8 broken sequence stays locked", d, 32'h0);
        wr(2'd1, 32'h1);
        rd(2'd1, d);
        check("R9 still ignored after bad keys", d, 32'h0);
        wr(2'd0, K1);
        wr(2'd0, K2);
        rd(2'd0, d);
        check("R8 unlocked after key pair", d, 32'h1);
        wr(2'd1, 32'h1);
        rd(2'd1, d);
        check("R9 bypass written when unlocked", d, 32'h1);
        wr(2'd0, 32'h0);
        rd(2'd0, d);
        check("R8 stray key write relocks", d, 32'h0);
    endtask

    task automatic t_bypass();
        int cyc;
        logic [31:0] d;
        pulse_destr();
        wait_run(cyc);
        check("R10 bypass reaches run", 32'(run_mode), 32'd1);
        check("R10 bypass no launch", 32'(n_start), 32'd0);
        rd(2'd2, d);
        check("R10 no test flag under bypass", d, 32'h2);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rd(2'd1, d);
        check("R9 power-on clears bypass", d, 32'h0);
        rst_n = 1'b1;
        n_start = 0;
        wait_run(cyc);
        check("R4 power-on reruns test", 32'(n_start), 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_por_flow();
        t_w1c();
        t_destr();
        t_short();
        t_midseq();
        t_keylock();
        t_bypass();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule